// File: doc/BRIEF.md
# Double-Buffered Span Paint Engine

This block accepts drawing commands from a host processor and paints horizontal runs of pixels into a small frame store that holds two complete pictures. Each command arrives as two 16-bit words, each qualified by a write strobe. The first word picks a row and a colour. The second word gives the first and last column of the run. Every pixel from the first column through the last, inclusive, is written with the colour in one cycle. Newer runs overwrite older ones, so the last write wins.

The two pictures take turns. One is the front picture, which scan-out logic reads through a combinational read port. The other is the back picture, which receives all drawing. The host asks for an exchange by sending the all-ones word in place of a first word. The exchange is held back until the next frame-start pulse from the display timing, so a frame is never shown half from one picture and half from the other. The block has no command queue. The host paces its words itself.

Top module: `span_paint_engine`

## Requirements
- R1: After reset, every pixel of both pictures holds colour index 0, `front_sel` is 0, and the next strobed word is taken as a first word.
- R2: A first word (strobed while a first word is expected and not equal to 16'hFFFF) latches the row from its low ROW_BITS bits and the 3-bit colour from bits [10:8]. Bits [15:11] and the row bits above ROW_BITS have no effect.
- R3: A second word takes the left column from the low COL_BITS bits of [7:0] and the right column from the low COL_BITS bits of [15:8]. On that strobe, every back-picture pixel of the latched row with left <= column <= right takes the latched colour.
- R4: When left is greater than right, a second word changes no pixel.
- R5: When the decoded row is ROWS or more, a second word changes no pixel.
- R6: A run overwrites earlier contents at the pixels it covers and leaves other pixels unchanged, so the last write wins.
- R7: Drawing goes only to the back picture (index `!front_sel`). The read port returns the front-picture pixel at (`rd_row`, `rd_col`) and does not change while no exchange takes place.
- R8: The word 16'hFFFF, strobed while a first word is expected, records a pending exchange, starts no run, and leaves the next word to be taken as a first word.
- R9: `front_sel` inverts on the clock edge where `frame_start` is high and an exchange was pending before that edge, and at no other time. An exchange requested in the same cycle as `frame_start` waits for the next pulse.
- R10: After an exchange, drawing goes to the picture that was previously shown.
- R11: Several exchange requests before one frame-start pulse produce a single inversion.
- R12: Words presented while `cmd_we` is low have no effect on pixels, on the word phase or on the exchange state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_we | input | 1 | Strobe qualifying `cmd_word` |
| cmd_word | input | 16 | Command word from the host |
| frame_start | input | 1 | One-cycle pulse at the start of vertical blank |
| rd_row | input | ROW_BITS (2) | Scan-out read row |
| rd_col | input | COL_BITS (2) | Scan-out read column |
| rd_color | output | CLR_W (3) | Front-picture colour at the read address |
| front_sel | output | 1 | Index of the picture now shown |

## Verification
The bench targets the edges of a run. It sends runs that start or end on the outermost columns, runs whose left index exceeds the right, rows past the last valid row, and field bits above the decoded width. A design that fills an exclusive range, or that wraps an inverted range, leaves a visible stripe that is wrong. The bench also sends exchange requests that coincide with a frame-start pulse, several requests before one pulse, and the all-ones word followed by an ordinary command. A design that inverts at the wrong time, inverts twice, or takes the next word as a second word shows the wrong picture. Idle cycles that carry junk on the command bus catch a decoder that samples without the strobe.

// File: rtl/spe_pkg.sv
package spe_pkg;

    localparam int WORD_W = 16;

    // bit positions inside the two command words
    localparam int ROW_LSB   = 0;
    localparam int CLR_LSB   = 8;
    localparam int LEFT_LSB  = 0;
    localparam int RIGHT_LSB = 8;

    localparam logic [WORD_W-1:0] SWAP_CODE = '1;

    typedef enum logic {
        PH_HEAD = 1'b0,
        PH_TAIL = 1'b1
    } word_phase_e;

endpackage

// File: rtl/spe_cmd_decode.sv
module spe_cmd_decode
    import spe_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    parameter int CLR_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_we,
    input  logic [WORD_W-1:0]   cmd_word,
    output logic                head_phase,
    output logic                swap_req,
    output logic                span_we,
    output logic [ROW_BITS-1:0] span_row,
    output logic [CLR_W-1:0]    span_color,
    output logic [COL_BITS-1:0] span_left,
    output logic [COL_BITS-1:0] span_right
);

    typedef struct packed {
        word_phase_e         phase;
        logic [ROW_BITS-1:0] row;
        logic [CLR_W-1:0]    color;
    } dec_state_t;

    dec_state_t st_d, st_q;

    // only some fields of each word are decoded
    logic unused_word_bits;
    assign unused_word_bits = ^cmd_word;

    always_comb begin
        st_d     = st_q;
        swap_req = 1'b0;
        span_we  = 1'b0;
        if (cmd_we) begin
            if (st_q.phase == PH_HEAD) begin
                if (cmd_word == SWAP_CODE) begin
                    swap_req = 1'b1;
                end else begin
                    st_d.row   = cmd_word[ROW_LSB +: ROW_BITS];
                    st_d.color = cmd_word[CLR_LSB +: CLR_W];
                    st_d.phase = PH_TAIL;
                end
            end else begin
                span_we    = 1'b1;
                st_d.phase = PH_HEAD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_HEAD;
            st_q.row   <= '0;
            st_q.color <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_phase = (st_q.phase == PH_HEAD);
    assign span_row   = st_q.row;
    assign span_color = st_q.color;
    assign span_left  = cmd_word[LEFT_LSB +: COL_BITS];
    assign span_right = cmd_word[RIGHT_LSB +: COL_BITS];

endmodule

// File: rtl/spe_span_mask.sv
module spe_span_mask #(
    parameter int COLS     = 4,
    parameter int COL_BITS = 2
) (
    input  logic [COL_BITS-1:0] left,
    input  logic [COL_BITS-1:0] right,
    output logic [COLS-1:0]     mask
);

    // one comparator pair per column; an inverted range selects nothing
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign mask[c] = (COL_BITS'(c) >= left) && (COL_BITS'(c) <= right);
    end

endmodule

// File: rtl/spe_buffer_ctrl.sv
module spe_buffer_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_req,
    input  logic frame_start,
    output logic front_sel,
    output logic swap_pending
);

    typedef struct packed {
        logic front;
        logic pending;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pending = (st_q.pending & ~frame_start) | swap_req;
        st_d.front   = st_q.front ^ (frame_start & st_q.pending);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign front_sel    = st_q.front;
    assign swap_pending = st_q.pending;

endmodule

// File: rtl/spe_frame_store.sv
module spe_frame_store #(
    parameter int ROWS     = 3,
    parameter int COLS     = 4,
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    parameter int CLR_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [ROW_BITS-1:0] wr_row,
    input  logic [CLR_W-1:0]    wr_color,
    input  logic [COLS-1:0]     wr_mask,
    input  logic                rd_sel,
    input  logic [ROW_BITS-1:0] rd_row,
    input  logic [COL_BITS-1:0] rd_col,
    output logic [CLR_W-1:0]    rd_color
);

    localparam int PICS = 2;

    logic [CLR_W-1:0] pix_d [PICS][ROWS][COLS];
    logic [CLR_W-1:0] pix_q [PICS][ROWS][COLS];

    // rows past ROWS match no entry and are clipped
    always_comb begin
        pix_d = pix_q;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (wr_en && (wr_row == ROW_BITS'(r)) && wr_mask[c]) begin
                    pix_d[wr_sel][r][c] = wr_color;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < PICS; b++) begin
                for (int r = 0; r < ROWS; r++) begin
                    for (int c = 0; c < COLS; c++) begin
                        pix_q[b][r][c] <= '0;
                    end
                end
            end
        end else begin
            pix_q <= pix_d;
        end
    end

    always_comb begin
        rd_color = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if ((rd_row == ROW_BITS'(r)) && (rd_col == COL_BITS'(c))) begin
                    rd_color = pix_q[rd_sel][r][c];
                end
            end
        end
    end

endmodule

// File: rtl/span_paint_engine.sv
module span_paint_engine
    import spe_pkg::*;
#(
    parameter int ROWS  = 3,
    parameter int COLS  = 4,
    parameter int CLR_W = 3,
    localparam int ROW_BITS = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_BITS = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_we,
    input  logic [15:0]         cmd_word,
    input  logic                frame_start,
    input  logic [ROW_BITS-1:0] rd_row,
    input  logic [COL_BITS-1:0] rd_col,
    output logic [CLR_W-1:0]    rd_color,
    output logic                front_sel
);

    logic                head_phase;
    logic                swap_req;
    logic                span_we;
    logic [ROW_BITS-1:0] span_row;
    logic [CLR_W-1:0]    span_color;
    logic [COL_BITS-1:0] span_left;
    logic [COL_BITS-1:0] span_right;
    logic [COLS-1:0]     span_mask;
    logic                swap_pending;

    spe_cmd_decode #(
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .CLR_W    (CLR_W)
    ) i_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .cmd_word   (cmd_word),
        .head_phase (head_phase),
        .swap_req   (swap_req),
        .span_we    (span_we),
        .span_row   (span_row),
        .span_color (span_color),
        .span_left  (span_left),
        .span_right (span_right)
    );

    spe_span_mask #(
        .COLS     (COLS),
        .COL_BITS (COL_BITS)
    ) i_mask (
        .left  (span_left),
        .right (span_right),
        .mask  (span_mask)
    );

    spe_buffer_ctrl i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .swap_req     (swap_req),
        .frame_start  (frame_start),
        .front_sel    (front_sel),
        .swap_pending (swap_pending)
    );

    spe_frame_store #(
        .ROWS     (ROWS),
        .COLS     (COLS),
        .ROW_BITS (ROW_BITS),
        .COL_BITS (COL_BITS),
        .CLR_W    (CLR_W)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (span_we),
        .wr_sel   (~front_sel),
        .wr_row   (span_row),
        .wr_color (span_color),
        .wr_mask  (span_mask),
        .rd_sel   (front_sel),
        .rd_row   (rd_row),
        .rd_col   (rd_col),
        .rd_color (rd_color)
    );

endmodule

// File: rtl/spe_checker.sv
module spe_checker #(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 2,
    parameter int CLR_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_we,
    input logic [15:0]         cmd_word,
    input logic                frame_start,
    input logic [ROW_BITS-1:0] rd_row,
    input logic [COL_BITS-1:0] rd_col,
    input logic [CLR_W-1:0]    rd_color,
    input logic                front_sel,
    input logic                swap_pending,
    input logic                head_phase
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (front_sel == 1'b0 && rd_color == '0));

    assert_read_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rd_row) && $stable(rd_col) && !$past(frame_start)) |-> $stable(rd_color));

    assert_swap_word_pends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && head_phase && cmd_word == 16'hFFFF) |=> (swap_pending && head_phase));

    assert_flip_at_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> ((front_sel != $past(front_sel)) == $past(swap_pending)));

    assert_no_flip_off_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(front_sel));

    assert_idle_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(head_phase));

endmodule

bind span_paint_engine spe_checker #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .CLR_W    (CLR_W)
) i_spe_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_we       (cmd_we),
    .cmd_word     (cmd_word),
    .frame_start  (frame_start),
    .rd_row       (rd_row),
    .rd_col       (rd_col),
    .rd_color     (rd_color),
    .front_sel    (front_sel),
    .swap_pending (swap_pending),
    .head_phase   (head_phase)
);

// File: tb/test_span_paint_engine.sv
`timescale 1ns/10ps
module test_span_paint_engine;

    localparam int ROWS     = 3;
    localparam int COLS     = 4;
    localparam int CLR_W    = 3;
    localparam int ROW_BITS = 2;
    localparam int COL_BITS = 2;

    logic                clk;
    logic                rst_n;
    logic                cmd_we;
    logic [15:0]         cmd_word;
    logic                frame_start;
    logic [ROW_BITS-1:0] rd_row;
    logic [COL_BITS-1:0] rd_col;
    logic [CLR_W-1:0]    rd_color;
    logic                front_sel;

    span_paint_engine #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .CLR_W (CLR_W)
    ) i_span_paint_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we),
        .cmd_word    (cmd_word),
        .frame_start (frame_start),
        .rd_row      (rd_row),
        .rd_col      (rd_col),
        .rd_color    (rd_color),
        .front_sel   (front_sel)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model
    logic [CLR_W-1:0] m_pix [2][ROWS][COLS];
    bit m_front, m_pend, m_tail;
    int m_row;
    logic [CLR_W-1:0] m_clr;

    function automatic logic [15:0] head_word(int row, int clr, int junk);
        return {junk[4:0], clr[2:0], row[7:0]};
    endfunction

    function automatic logic [15:0] tail_word(int left, int right);
        return {right[7:0], left[7:0]};
    endfunction

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(bit we, logic [15:0] w, bit fs);
        bit flip;
        bit req;
        int lft;
        int rgt;
        @(negedge clk);
        cmd_we      = we;
        cmd_word    = w;
        frame_start = fs;
        @(posedge clk);
        flip = fs && m_pend;
        req  = 1'b0;
        if (we) begin
            if (!m_tail) begin
                if (w == 16'hFFFF) begin
                    req = 1'b1;
                end else begin
                    m_row  = int'(w[ROW_BITS-1:0]);
                    m_clr  = w[8 +: CLR_W];
                    m_tail = 1'b1;
                end
            end else begin
                lft = int'(w[COL_BITS-1:0]);
                rgt = int'(w[8 +: COL_BITS]);
                if (m_row < ROWS) begin
                    for (int c = 0; c < COLS; c++) begin
                        if (c >= lft && c <= rgt) m_pix[!m_front][m_row][c] = m_clr;
                    end
                end
                m_tail = 1'b0;
            end
        end
        m_pend = (m_pend && !fs) || req;
        if (flip) m_front = !m_front;
    endtask

    task automatic draw(int row, int clr, int left, int right);
        step(1'b1, head_word(row, clr, 0), 1'b0);
        step(1'b1, tail_word(left, right), 1'b0);
    endtask

    task automatic swap_and_show();
        step(1'b1, 16'hFFFF, 1'b0);
        step(1'b0, 16'h0000, 1'b1);
    endtask

    task automatic check_front(string tag);
        @(negedge clk);
        cmd_we      = 1'b0;
        frame_start = 1'b0;
        check_eq({tag, " front_sel"}, int'(front_sel), int'(m_front));
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                rd_row = ROW_BITS'(r);
                rd_col = COL_BITS'(c);
                #0.1;
                check_eq($sformatf("%s pixel r%0d c%0d", tag, r, c),
                         int'(rd_color), int'(m_pix[m_front][r][c]));
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++)
                    m_pix[b][r][c] = '0;
        m_front = 1'b0;
        m_pend  = 1'b0;
        m_tail  = 1'b0;
        m_row   = 0;
        m_clr   = '0;

        rst_n       = 1'b0;
        cmd_we      = 1'b0;
        cmd_word    = 16'h0000;
        frame_start = 1'b0;
        rd_row      = '0;
        rd_col      = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared pictures, picture 0 in front
        check_front("R1");

        // R2: junk in [15:11] ignored; R7: back drawing invisible
        step(1'b1, head_word(1, 5, 31), 1'b0);
        step(1'b1, tail_word(1, 2), 1'b0);
        check_front("R7");
        // R9: a pending request alone does not flip
        step(1'b1, 16'hFFFF, 1'b0);
        check_front("R9 pending");
        step(1'b0, 16'h0000, 1'b1);
        check_front("R3 R2 inclusive span");

        // R10: draw into the old front, edges of the row
        draw(0, 7, 0, 3);
        draw(2, 3, 3, 3);
        swap_and_show();
        check_front("R10");

        // R4: inverted range writes nothing
        draw(1, 6, 3, 1);
        // R5: row past the end is clipped; upper row bits ignored (row 5 -> 1)
        draw(3, 4, 0, 3);
        draw(5, 2, 0, 0);
        swap_and_show();
        check_front("R4 R5 R2");

        // R6: overlap, last write wins
        draw(2, 1, 0, 2);
        draw(2, 4, 1, 3);
        draw(2, 6, 2, 2);
        swap_and_show();
        check_front("R6");

        // R11: two requests, one pulse -> one flip
        step(1'b1, 16'hFFFF, 1'b0);
        step(1'b1, 16'hFFFF, 1'b0);
        step(1'b0, 16'h0000, 1'b1);
        check_front("R11");

        // R9: request coinciding with the pulse waits for the next pulse
        step(1'b1, 16'hFFFF, 1'b1);
        check_front("R9 coincident");
        step(1'b0, 16'h0000, 1'b1);
        check_front("R9 next pulse");

        // R8: word after the swap code is a first word
        step(1'b1, 16'hFFFF, 1'b0);
        step(1'b1, head_word(0, 2, 0), 1'b0);
        step(1'b1, tail_word(0, 1), 1'b0);
        step(1'b0, 16'h0000, 1'b1);
        check_front("R8");

        // R12: junk without strobe between the two words
        step(1'b1, head_word(1, 3, 0), 1'b0);
        for (int i = 0; i < 8; i++) step(1'b0, 16'($urandom), 1'b0);
        step(1'b1, tail_word(0, 3), 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 16'hFFFF, 1'b0);
        swap_and_show();
        check_front("R12");

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            int sel;
            logic [15:0] w;
            sel = int'($urandom % 100);
            w   = 16'($urandom);
            if ($urandom % 16 == 0) w = 16'hFFFF;
            if (sel < 70)      step(1'b1, w, 1'b0);
            else if (sel < 80) step(1'b1, w, 1'b1);
            else if (sel < 90) step(1'b0, w, 1'b1);
            else               step(1'b0, w, 1'b0);
            if (i % 30 == 29) check_front("R6 R3 random");
        end
        swap_and_show();
        check_front("R6 R3 random final");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule